// File: doc/BRIEF.md
# Asymmetric Two-Unit Arithmetic Dispatcher

The dispatcher takes up to two decoded arithmetic operations per cycle from a two-slot issue bus and places them onto a pair of execution units. The units differ: unit 0 can add and multiply, while unit 1 can only add. An addition may go to either unit. A multiplication can only go to unit 0, and it holds that unit for five cycles. An addition holds its unit for a single cycle. Each unit returns its result with the destination tag of the operation that produced it, on its own result port.

Each slot has a valid, an opcode bit, two 32-bit operands and a destination tag. A ready line comes back per slot. An operation moves on the clock edge where its valid and ready are both high. A slot that cannot be placed sees ready low, and the producer keeps the operation on the bus until a unit opens. Each unit runs a small state machine with two states. `U_IDLE` accepts work. `U_MULT` counts down a multiplication. The transition `U_IDLE -> U_MULT` fires when a multiplication is issued. The transition `U_MULT -> U_IDLE` fires when the countdown reaches zero, and the product comes out on that same edge. An addition issued in `U_IDLE` keeps the unit in `U_IDLE`.

Top module: `alu_pair_dispatch`

## Requirements
- R1: After reset both result valids are low, and a slot whose valid is low always sees its ready low.
- R2: An addition goes to unit 0 whenever unit 0 is free. With two additions offered and unit 0 free, slot 0 goes to unit 0 and slot 1 goes to unit 1, and both readies are high.
- R3: A multiplication (opcode bit 1; an opcode bit of 0 means addition) is only ever placed on unit 0. When a multiplication and an addition are offered together and unit 0 is free, the multiplication takes unit 0 and the addition takes unit 1, whichever slots they sit in.
- R4: While unit 0 is busy, an addition is placed on unit 1. If two additions are offered in that state, slot 0 is taken and slot 1 waits with ready low.
- R5: A multiplication accepted on edge E keeps unit 0 from accepting anything on edges E+1 through E+4. Unit 0 accepts again on edge E+5.
- R6: An addition accepted on edge E has its result valid right after E. A multiplication accepted on edge E has its result valid right after edge E+4. Each result valid lasts one cycle.
- R7: When both slots hold multiplications and unit 0 is free, slot 0 is taken and slot 1 waits with ready low.
- R8: An addition result is the sum modulo 2^32. A multiplication result is the low 32 bits of the product. Every result carries the tag of the operation that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_vld | input | 1 | Slot 0 holds an operation |
| s0_mul | input | 1 | Slot 0 opcode: 1 multiply, 0 add |
| s0_a | input | 32 | Slot 0 first operand |
| s0_b | input | 32 | Slot 0 second operand |
| s0_tag | input | 5 | Slot 0 destination tag |
| s0_rdy | output | 1 | Slot 0 is placed this cycle |
| s1_vld | input | 1 | Slot 1 holds an operation |
| s1_mul | input | 1 | Slot 1 opcode: 1 multiply, 0 add |
| s1_a | input | 32 | Slot 1 first operand |
| s1_b | input | 32 | Slot 1 second operand |
| s1_tag | input | 5 | Slot 1 destination tag |
| s1_rdy | output | 1 | Slot 1 is placed this cycle |
| r0_vld | output | 1 | Unit 0 result valid |
| r0_data | output | 32 | Unit 0 result value |
| r0_tag | output | 5 | Unit 0 result tag |
| r1_vld | output | 1 | Unit 1 result valid |
| r1_data | output | 32 | Unit 1 result value |
| r1_tag | output | 5 | Unit 1 result tag |

## Verification
The bench offers a multiplication in slot 1 behind an addition in slot 0. A design that ranks by slot instead of by opcode would give the addition unit 0 and leave the multiplication stuck. The bench also offers a multiplication on every cycle of the busy window. A countdown that is off by one would accept it one edge too early or too late, and both show up as a ready mismatch and a misplaced product. The bench sends two multiplications together, which catches a design that drops the second one or lets it reach unit 1. Operands that wrap around 32 bits catch a result taken from the wrong half of the product or an adder with a lost carry.

// File: rtl/alu_pair_pkg.sv
package alu_pair_pkg;
    localparam int NUM_UNITS = 2;

    typedef enum logic {
        U_IDLE = 1'b0,
        U_MULT = 1'b1
    } unit_state_e;
endpackage

// File: rtl/alu_slot_router.sv
module alu_slot_router (
    input  logic       vld0,
    input  logic       mul0,
    input  logic       vld1,
    input  logic       mul1,
    input  logic       free0,
    input  logic       free1,
    output logic       go0,
    output logic       dst0,
    output logic       go1,
    output logic       dst1
);
    logic avail0;
    logic avail1;

    always_comb begin
        go0    = 1'b0;
        go1    = 1'b0;
        dst0   = 1'b0;
        dst1   = 1'b0;
        avail0 = free0;
        avail1 = free1;
        // Multiplies claim unit 0 first, oldest slot first.
        if (vld0 && mul0 && avail0) begin
            go0    = 1'b1;
            dst0   = 1'b0;
            avail0 = 1'b0;
        end
        if (vld1 && mul1 && avail0) begin
            go1    = 1'b1;
            dst1   = 1'b0;
            avail0 = 1'b0;
        end
        // Adds take unit 0 if still open, otherwise unit 1.
        if (vld0 && !mul0) begin
            if (avail0) begin
                go0    = 1'b1;
                dst0   = 1'b0;
                avail0 = 1'b0;
            end else if (avail1) begin
                go0    = 1'b1;
                dst0   = 1'b1;
                avail1 = 1'b0;
            end
        end
        if (vld1 && !mul1) begin
            if (avail0) begin
                go1    = 1'b1;
                dst1   = 1'b0;
                avail0 = 1'b0;
            end else if (avail1) begin
                go1    = 1'b1;
                dst1   = 1'b1;
                avail1 = 1'b0;
            end
        end
    end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 5,
    parameter bit HAS_MUL = 1'b1,
    parameter int MUL_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_mul,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [TAG_W-1:0]  tag,
    output logic              free,
    output logic              res_vld,
    output logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag
);
    import alu_pair_pkg::*;

    localparam int CNT_W = (MUL_LAT > 2) ? $clog2(MUL_LAT) : 1;

    unit_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] hold_a, hold_b;
    logic [TAG_W-1:0]  hold_tag;
    logic              take_mul;
    logic              mul_done;

    assign take_mul = HAS_MUL && issue_mul;
    assign free     = (state_q == U_IDLE);
    assign mul_done = (state_q == U_MULT) && (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE: if (issue && take_mul) state_d = U_MULT;
            U_MULT: if (cnt_q == '0)       state_d = U_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == U_IDLE && issue && take_mul)
                cnt_q <= CNT_W'(MUL_LAT - 2);
            else if (state_q == U_MULT)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_data <= '0;
            res_tag  <= '0;
            hold_a   <= '0;
            hold_b   <= '0;
            hold_tag <= '0;
        end else begin
            res_vld <= 1'b0;
            if (free && issue) begin
                hold_a   <= opa;
                hold_b   <= opb;
                hold_tag <= tag;
                if (!take_mul) begin
                    res_vld  <= 1'b1;
                    res_data <= opa + opb;
                    res_tag  <= tag;
                end
            end
            if (mul_done) begin
                res_vld  <= 1'b1;
                res_data <= hold_a * hold_b;
                res_tag  <= hold_tag;
            end
        end
    end

    assert_add_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && free && !take_mul) |=> res_vld);

    assert_mul_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |=> (res_vld && state_q == U_IDLE));

    generate
        if (!HAS_MUL) begin : g_add_only
            assert_no_mul_here_R3: assert property (@(posedge clk) disable iff (!rst_n)
                issue |-> !issue_mul);
        end
    endgenerate
endmodule

// File: rtl/alu_pair_dispatch.sv
module alu_pair_dispatch #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 5,
    parameter int MUL_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s0_vld,
    input  logic              s0_mul,
    input  logic [DATA_W-1:0] s0_a,
    input  logic [DATA_W-1:0] s0_b,
    input  logic [TAG_W-1:0]  s0_tag,
    output logic              s0_rdy,
    input  logic              s1_vld,
    input  logic              s1_mul,
    input  logic [DATA_W-1:0] s1_a,
    input  logic [DATA_W-1:0] s1_b,
    input  logic [TAG_W-1:0]  s1_tag,
    output logic              s1_rdy,
    output logic              r0_vld,
    output logic [DATA_W-1:0] r0_data,
    output logic [TAG_W-1:0]  r0_tag,
    output logic              r1_vld,
    output logic [DATA_W-1:0] r1_data,
    output logic [TAG_W-1:0]  r1_tag
);
    import alu_pair_pkg::*;

    logic              go0, go1, dst0, dst1;
    logic              u_free  [NUM_UNITS];
    logic              u_issue [NUM_UNITS];
    logic              u_mul   [NUM_UNITS];
    logic [DATA_W-1:0] u_a     [NUM_UNITS];
    logic [DATA_W-1:0] u_b     [NUM_UNITS];
    logic [TAG_W-1:0]  u_tag   [NUM_UNITS];
    logic              u_rv    [NUM_UNITS];
    logic [DATA_W-1:0] u_rd    [NUM_UNITS];
    logic [TAG_W-1:0]  u_rt    [NUM_UNITS];

    alu_slot_router router (
        .vld0  (s0_vld),
        .mul0  (s0_mul),
        .vld1  (s1_vld),
        .mul1  (s1_mul),
        .free0 (u_free[0]),
        .free1 (u_free[1]),
        .go0   (go0),
        .dst0  (dst0),
        .go1   (go1),
        .dst1  (dst1)
    );

    assign s0_rdy = go0;
    assign s1_rdy = go1;

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            logic from0, from1;
            assign from0      = go0 && (dst0 == 1'(u));
            assign from1      = go1 && (dst1 == 1'(u));
            assign u_issue[u] = from0 || from1;
            assign u_mul[u]   = from0 ? s0_mul : s1_mul;
            assign u_a[u]     = from0 ? s0_a   : s1_a;
            assign u_b[u]     = from0 ? s0_b   : s1_b;
            assign u_tag[u]   = from0 ? s0_tag : s1_tag;

            alu_exec_unit #(
                .DATA_W  (DATA_W),
                .TAG_W   (TAG_W),
                .HAS_MUL (u == 0),
                .MUL_LAT (MUL_LAT)
            ) unit (
                .clk       (clk),
                .rst_n     (rst_n),
                .issue     (u_issue[u]),
                .issue_mul (u_mul[u]),
                .opa       (u_a[u]),
                .opb       (u_b[u]),
                .tag       (u_tag[u]),
                .free      (u_free[u]),
                .res_vld   (u_rv[u]),
                .res_data  (u_rd[u]),
                .res_tag   (u_rt[u])
            );
        end
    endgenerate

    assign r0_vld  = u_rv[0];
    assign r0_data = u_rd[0];
    assign r0_tag  = u_rt[0];
    assign r1_vld  = u_rv[1];
    assign r1_data = u_rd[1];
    assign r1_tag  = u_rt[1];

    assert_rdy_needs_vld_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!s0_vld |-> !s0_rdy) and (!s1_vld |-> !s1_rdy));

    assert_busy_unit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !u_free[0] |-> !u_issue[0]);

    assert_dual_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld && !s0_mul && s1_vld && !s1_mul && u_free[0]) |-> (s0_rdy && s1_rdy));

    assert_mul_stays_on_unit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_rdy && s0_mul) |-> !dst0);
endmodule

// File: tb/alu_pair_dispatch_test.sv
module alu_pair_dispatch_test;
    localparam int DW  = 32;
    localparam int TW  = 5;
    localparam int LAT = 5;

    typedef struct {
        logic [DW-1:0] data;
        logic [TW-1:0] tag;
        int            due;
        string         req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_vld = 1'b0, s0_mul = 1'b0, s1_vld = 1'b0, s1_mul = 1'b0;
    logic [DW-1:0] s0_a = '0, s0_b = '0, s1_a = '0, s1_b = '0;
    logic [TW-1:0] s0_tag = '0, s1_tag = '0;
    logic s0_rdy, s1_rdy, r0_vld, r1_vld;
    logic [DW-1:0] r0_data, r1_data;
    logic [TW-1:0] r0_tag, r1_tag;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;
    exp_t q0[$];
    exp_t q1[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    alu_pair_dispatch #(.DATA_W(DW), .TAG_W(TW), .MUL_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n),
        .s0_vld(s0_vld), .s0_mul(s0_mul), .s0_a(s0_a), .s0_b(s0_b), .s0_tag(s0_tag), .s0_rdy(s0_rdy),
        .s1_vld(s1_vld), .s1_mul(s1_mul), .s1_a(s1_a), .s1_b(s1_b), .s1_tag(s1_tag), .s1_rdy(s1_rdy),
        .r0_vld(r0_vld), .r0_data(r0_data), .r0_tag(r0_tag),
        .r1_vld(r1_vld), .r1_data(r1_data), .r1_tag(r1_tag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input bit m, input logic [DW-1:0] a, input logic [DW-1:0] b,
                                      input logic [TW-1:0] t, input string req);
        exp_t e;
        e.data = m ? DW'(a * b) : DW'(a + b);
        e.tag  = t;
        e.due  = cyc + (m ? LAT : 1);
        e.req  = req;
        return e;
    endfunction

    task automatic drive(input bit v0, input bit m0, input logic [DW-1:0] a0, input logic [DW-1:0] b0,
                         input logic [TW-1:0] t0,
                         input bit v1, input bit m1, input logic [DW-1:0] a1, input logic [DW-1:0] b1,
                         input logic [TW-1:0] t1,
                         input bit er0, input bit er1, input bit eu0, input bit eu1, input string req);
        @(negedge clk);
        s0_vld = v0; s0_mul = m0; s0_a = a0; s0_b = b0; s0_tag = t0;
        s1_vld = v1; s1_mul = m1; s1_a = a1; s1_b = b1; s1_tag = t1;
        #1;
        check(s0_rdy == er0, req, "slot0 ready", DW'(s0_rdy), DW'(er0));
        check(s1_rdy == er1, req, "slot1 ready", DW'(s1_rdy), DW'(er1));
        if (er0) begin
            if (eu0) q1.push_back(make_exp(m0, a0, b0, t0, req));
            else     q0.push_back(make_exp(m0, a0, b0, t0, req));
        end
        if (er1) begin
            if (eu1) q1.push_back(make_exp(m1, a1, b1, t1, req));
            else     q0.push_back(make_exp(m1, a1, b1, t1, req));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s0_vld = 1'b0;
            s1_vld = 1'b0;
        end
    endtask

    // Monitor: pops the per-unit scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (r0_vld) begin
                if (q0.size() == 0) begin
                    check(1'b0, "R6", "unexpected unit0 result", r0_data, '0);
                end else begin
                    exp_t e;
                    e = q0.pop_front();
                    check(r0_data == e.data, "R8", {e.req, " unit0 data"}, r0_data, e.data);
                    check(r0_tag == e.tag, "R8", "unit0 tag", DW'(r0_tag), DW'(e.tag));
                    check(cyc == e.due, "R6", "unit0 result cycle", DW'(cyc), DW'(e.due));
                end
            end
            if (r1_vld) begin
                if (q1.size() == 0) begin
                    check(1'b0, "R6", "unexpected unit1 result", r1_data, '0);
                end else begin
                    exp_t e;
                    e = q1.pop_front();
                    check(r1_data == e.data, "R8", {e.req, " unit1 data"}, r1_data, e.data);
                    check(r1_tag == e.tag, "R8", "unit1 tag", DW'(r1_tag), DW'(e.tag));
                    check(cyc == e.due, "R6", "unit1 result cycle", DW'(cyc), DW'(e.due));
                end
            end
        end
    end

    task automatic report;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(!r0_vld && !r1_vld, "R1", "result valid after reset", DW'({r0_vld, r1_vld}), '0);
        check(!s0_rdy && !s1_rdy, "R1", "ready with no valid", DW'({s0_rdy, s1_rdy}), '0);

        // R2: two adds, unit 0 free
        drive(1, 0, 3, 4, 1,   1, 0, 10, 20, 2,   1, 1, 0, 1, "R2");
        // R3: multiply in slot 0 beside an add
        drive(1, 1, 6, 7, 3,   1, 0, 1, 1, 4,     1, 1, 0, 1, "R3");
        // R4: unit 0 busy, two adds: slot 0 to unit 1, slot 1 waits
        drive(1, 0, 5, 5, 5,   1, 0, 2, 2, 6,     1, 0, 1, 0, "R4");
        // R5: multiply held off while busy; the add behind it goes to unit 1
        drive(1, 1, 32'hFFFF_FFFF, 2, 7,   1, 0, 2, 2, 6,   0, 1, 0, 1, "R5");
        drive(1, 1, 32'hFFFF_FFFF, 2, 7,   0, 0, 0, 0, 0,   0, 0, 0, 0, "R5");
        drive(1, 1, 32'hFFFF_FFFF, 2, 7,   0, 0, 0, 0, 0,   0, 0, 0, 0, "R5");
        // R5/R7: unit 0 free on the fifth edge; two multiplies, slot 1 waits
        drive(1, 1, 32'hFFFF_FFFF, 2, 7,   1, 1, 9, 9, 8,   1, 0, 0, 0, "R7");
        // R5: slot 1 multiply waits out the busy window
        for (int i = 0; i < 4; i++)
            drive(0, 0, 0, 0, 0,   1, 1, 9, 9, 8,   0, 0, 0, 0, "R5");
        drive(0, 0, 0, 0, 0,   1, 1, 9, 9, 8,   0, 1, 0, 0, "R3");
        idle(4);
        // R3: add in slot 0, multiply in slot 1; wrap-around add for R8
        drive(1, 0, 32'hFFFF_FFFF, 1, 9,   1, 1, 32'h8000_0003, 32'h0001_0005, 10,   1, 1, 1, 0, "R3");
        // R4: single add in slot 1 while unit 0 busy
        drive(0, 0, 0, 0, 0,   1, 0, 7, 8, 11,   0, 1, 0, 1, "R4");
        idle(6);
        // R2: lone add goes to unit 0 when free
        drive(1, 0, 40, 2, 12,   0, 0, 0, 0, 0,   1, 0, 0, 0, "R2");
        // R1: dropping valid drops ready
        drive(0, 0, 0, 0, 0,   0, 0, 0, 0, 0,   0, 0, 0, 0, "R1");
        idle(8);
        check(q0.size() == 0, "R6", "unit0 results outstanding", DW'(q0.size()), '0);
        check(q1.size() == 0, "R6", "unit1 results outstanding", DW'(q1.size()), '0);
        report();
    end
endmodule